// File: doc/BRIEF.md
# Supply Recharge Activity Monitor

This block observes how often a retained supply rail has to be recharged while the system sits in standby. A slow tick from the 32 kHz domain, presented as a one-cycle pulse, advances a period counter. A recharge-start pulse marks the beginning of each recharge. On every recharge start the block takes one sample of a rail comparator. That comparator reports whether the rail was still above its OK threshold.

The samples feed a short shift history. The count of slow periods since the previous recharge feeds a peak tracker. The peak tracker only accepts a spacing when the rail was still good at the later recharge, so the peak is a measure of how long the rail can hold charge, which indicates standby leakage. Both values are read through one 32-bit status word. Any write strobe to that word clears the peak so that software can start a new measurement window.

Top module: `rail_recharge_mon`

## Requirements
- R1: The status word carries the sample history in bits 19:16 and the peak period count in bits 15:0; bits 31:20 always read 0.
- R2: On each recharge-start pulse the history shifts toward the high bit by one place and bit 16 takes the new sample; without a recharge start the history holds.
- R3: A sample bit is 1 when the rail comparator input is high (rail above threshold) in the recharge-start cycle, and 0 when it is low.
- R4: On a recharge start with the comparator high, if an earlier recharge start has occurred since reset and the period count is larger than the stored peak, the peak takes the period count; the first recharge start after reset never changes the peak.
- R5: A write strobe clears the peak field to 0 in the next cycle and leaves the history unchanged.
- R6: The period count is the number of tick pulses in the cycles strictly between two recharge starts; it restarts at 0 on every recharge start (a tick in that same cycle is not counted) and saturates at 0xFFFF instead of wrapping.
- R7: A recharge start with the comparator low leaves the peak unchanged but still restarts the period count.
- R8: A write strobe in the same cycle as a peak update wins: the peak reads 0 afterwards.
- R9: After reset the whole status word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle pulse per 32 kHz period |
| rech_start_i | input | 1 | One-cycle pulse at the start of a recharge |
| rail_ok_i | input | 1 | Rail comparator, high when above threshold |
| stat_wr_i | input | 1 | Write strobe to the status word; clears the peak |
| status_o | output | 32 | Status word: history and peak period count |

## Verification
The hardest case to reach from the ports is a saturated period count feeding the peak, because it needs more than 65535 tick pulses between two recharges. The bench holds the tick high for about seventy thousand cycles, with intermediate checks switched off, and then issues a good-rail recharge to confirm that the peak reads 0xFFFF. A write that coincides with a qualifying update, a first recharge after reset with a long spacing, and a tick that lands in the recharge-start cycle are each driven as separate cases.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam int unsigned RCM_CNT_W  = 16;
    localparam int unsigned RCM_HIST_W = 4;
    localparam int unsigned RCM_STAT_W = 32;

    typedef struct packed {
        logic tick;
        logic rech;
        logic ok;
        logic clr;
    } rcm_evt_t;

endpackage

// File: rtl/rcm_period_cnt.sv
module rcm_period_cnt #(
    parameter int unsigned CNT_W = rcm_pkg::RCM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (count_o == '0)); // R6
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && tick_i && (count_o == CNT_MAX)) |=> (count_o == CNT_MAX)); // R6
    AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !tick_i) |=> $stable(count_o)); // R6

endmodule

// File: rtl/rcm_sample_hist.sv
module rcm_sample_hist #(
    parameter int unsigned HIST_W = rcm_pkg::RCM_HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              sample_i,
    output logic [HIST_W-1:0] hist_o
);

    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) begin
            st_d.bits = {st_q.bits[HIST_W-2:0], sample_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist_o = st_q.bits;

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (hist_o[0] == $past(sample_i))); // R3
    AST_HIST_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0]))); // R2
    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(hist_o)); // R2

endmodule

// File: rtl/rcm_peak_track.sv
module rcm_peak_track #(
    parameter int unsigned CNT_W = rcm_pkg::RCM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             rail_ok_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] peak_o
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] peak;
    } peak_st_t;

    peak_st_t st_d, st_q;
    logic     take_new;

    always_comb begin
        st_d     = st_q;
        take_new = capture_i && rail_ok_i && st_q.armed && (count_i > st_q.peak);
        if (capture_i) begin
            st_d.armed = 1'b1;
        end
        if (clear_i) begin
            st_d.peak = '0;
        end else if (take_new) begin
            st_d.peak = count_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign peak_o = st_q.peak;

    AST_PEAK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (peak_o == '0)); // R5 R8
    AST_PEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (peak_o >= $past(peak_o))); // R4
    AST_PEAK_LOW_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !rail_ok_i && !clear_i) |=> $stable(peak_o)); // R7
    AST_PEAK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i && !clear_i) |=> $stable(peak_o)); // R4
    AST_PEAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !st_q.armed && !clear_i) |=> $stable(peak_o)); // R4
    AST_PEAK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && rail_ok_i && st_q.armed && !clear_i && (count_i > peak_o))
        |=> (peak_o == $past(count_i))); // R4

endmodule

// File: rtl/rail_recharge_mon.sv
module rail_recharge_mon #(
    parameter int unsigned CNT_W  = rcm_pkg::RCM_CNT_W,
    parameter int unsigned HIST_W = rcm_pkg::RCM_HIST_W,
    parameter int unsigned STAT_W = rcm_pkg::RCM_STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick_i,
    input  logic              rech_start_i,
    input  logic              rail_ok_i,
    input  logic              stat_wr_i,
    output logic [STAT_W-1:0] status_o
);

    localparam int unsigned PAD_W = STAT_W - HIST_W - CNT_W;

    rcm_pkg::rcm_evt_t evt;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  peak;
    logic [HIST_W-1:0] hist;

    assign evt.tick = slow_tick_i;
    assign evt.rech = rech_start_i;
    assign evt.ok   = rail_ok_i;
    assign evt.clr  = stat_wr_i;

    rcm_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (evt.tick),
        .restart_i (evt.rech),
        .count_o   (count)
    );

    rcm_sample_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (evt.rech),
        .sample_i (evt.ok),
        .hist_o   (hist)
    );

    rcm_peak_track #(.CNT_W(CNT_W)) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (evt.rech),
        .rail_ok_i (evt.ok),
        .clear_i   (evt.clr),
        .count_i   (count),
        .peak_o    (peak)
    );

    assign status_o = {{PAD_W{1'b0}}, hist, peak};

    AST_HIST_UNTOUCHED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && !rech_start_i) |=> $stable(status_o[CNT_W +: HIST_W])); // R5
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0) || !rst_n); // R9

endmodule

// File: tb/rail_recharge_mon_tb.sv
`timescale 1ns/1ps
module rail_recharge_mon_tb;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick_i = 1'b0;
    logic        rech_start_i = 1'b0;
    logic        rail_ok_i = 1'b0;
    logic        stat_wr_i = 1'b0;
    logic [31:0] status_o;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    logic [15:0] m_cnt = '0;
    logic [15:0] m_peak = '0;
    logic [3:0]  m_hist = '0;
    bit          m_armed = 1'b0;

    always #2 clk = ~clk;

    rail_recharge_mon u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slow_tick_i  (slow_tick_i),
        .rech_start_i (rech_start_i),
        .rail_ok_i    (rail_ok_i),
        .stat_wr_i    (stat_wr_i),
        .status_o     (status_o)
    );

    // Driver: one cycle of stimulus, expected value pushed after the edge
    task automatic step(input logic tk, input logic rs, input logic ok,
                        input logic wr, input bit chk, input string tag);
        @(negedge clk);
        slow_tick_i  = tk;
        rech_start_i = rs;
        rail_ok_i    = ok;
        stat_wr_i    = wr;
        if (rs) begin
            if (m_armed && ok && (m_cnt > m_peak)) m_peak = m_cnt;
            m_hist  = {m_hist[2:0], ok};
            m_cnt   = '0;
            m_armed = 1'b1;
        end else if (tk && (m_cnt != 16'hFFFF)) begin
            m_cnt = m_cnt + 16'd1;
        end
        if (wr) m_peak = '0;
        @(posedge clk);
        #1;
        if (chk) sb_q.push_back('{exp: {12'h000, m_hist, m_peak}, tag: tag});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "");
    endtask

    // Monitor: compares queued expectations against the status word
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (status_o !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: status actual %h expected %h", it.tag, status_o, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (status_o !== 32'h0) begin
            n_errors++;
            $display("FAIL R9: reset status actual %h expected %h", status_o, 32'h0);
        end
        rst_n = 1'b1;

        // R4: first recharge never updates the peak, even after a long spacing
        ticks(5);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 first recharge");
        // R4 R3: good rail with spacing 7
        ticks(7);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 capture 7");
        idle(2);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2 history holds");
        // R4: smaller spacing does not lower the peak
        ticks(3);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R4 smaller kept");
        // R7: low rail with larger spacing leaves peak
        ticks(10);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7 low rail");
        // R6: counter restarted at low-rail recharge
        ticks(12);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 restart then capture 12");
        // R5: write clears peak, history unchanged
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 write clears");
        // R8: write coinciding with a qualifying update
        ticks(4);
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8 clear wins");
        // R6: tick in the recharge cycle is not counted
        ticks(2);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R6 tick with recharge");
        ticks(2);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 count excludes coincident tick");
        // R2 R3: mixed history pattern
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 low sample");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R2 shift pattern");
        // R1: upper bits stay zero with full fields
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1 layout");
        // R6: saturation at 0xFFFF
        ticks(70000);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R6 saturated peak");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 clear after saturation");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule